// File: doc/BRIEF.md
# Dual-I/O Flash Read Sequencer

This block is the host end of a serial flash read that moves address, mode and data two bits per clock. A user asserts `start` for one clock with a 24-bit start address, a byte count (given as count minus one) and an 8-bit mode byte. The sequencer pulls chip select low and, in the normal case, sends the read command `8'hBB` on data line 0 alone. It then sends the address and the mode byte over both data lines. After that it releases the lines and collects read bytes, two bits per clock. Each finished byte appears on `rd_data` with a one-clock `rd_valid` pulse.

The serial clock runs in SPI mode 0. It idles low and comes from the system clock through a divider of `CLK_DIV` system clocks per period. Host outputs change only while the serial clock is falling, and read data is sampled as it rises.

If the mode byte of a transaction has bits [5:4] equal to `2'b10`, the flash stays in a continuous-read condition. The next transaction then starts directly with the address and skips the command. Any other value on those bits clears this condition, and so does reset.

The sequencer states are:
- `ST_IDLE` goes to `ST_OPC` on an accepted start, or to `ST_ADDR` when continuous mode is set.
- `ST_OPC` goes to `ST_ADDR` after 8 serial clocks.
- `ST_ADDR` goes to `ST_MODE` after 12.
- `ST_MODE` goes to `ST_DATA` after 4.
- `ST_DATA` goes to `ST_GAP` after 4 clocks per byte, raising chip select.
- `ST_GAP` goes back to `ST_IDLE` after `GAP_CYC` system clocks.

Top module: `dio_read_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` is 0, `io_oe` is 2'b00 and `rd_valid` is 0.
- R2: When continuous mode is clear, the first 8 serial clocks carry `8'hBB`, most significant bit first, on `io_o[0]`, with `io_oe` = 2'b01 (line 1 not driven).
- R3: The 24 address bits follow as 12 serial clocks, most significant pair first. In each clock `io_o[1]` carries the odd-numbered bit (A23, A21, …) and `io_o[0]` the even one (A22, A20, …), with `io_oe` = 2'b11.
- R4: The mode byte follows the address as 4 serial clocks with the same pairing: bits 7/6 first, then 5/4, 3/2 and 1/0.
- R5: Each read byte takes 4 serial clocks. `io_i[1]` carries bits 7, 5, 3, 1 and `io_i[0]` carries bits 6, 4, 2, 0. The byte is presented on `rd_data` with a one-clock `rd_valid` pulse in the cycle the serial clock rises for its last pair. Exactly `len_m1`+1 bytes are delivered, in address order.
- R6: `io_oe` is 2'b00 from the first data clock until chip select rises.
- R7: `sck` is low whenever `cs_n` is high. `io_o` and `io_oe` never change while `sck` stays high.
- R8: Consecutive rising edges of `sck` within a transaction are `CLK_DIV` system clocks apart.
- R9: A transaction whose mode bits [5:4] are 2'b10 makes the next one skip the command and start with the address. Any other value, or reset, makes the next one send the command again.
- R10: `cs_n` rises right after the last data clock of the transaction and stays high for `GAP_CYC` (at least 2) system clocks. During that time `busy` stays high. `busy` is high from the cycle after an accepted start until that gap ends, and is always high while `cs_n` is low.
- R11: A `start` pulse while `busy` is high is ignored. It neither changes the running transaction nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a read |
| start_addr | input | 24 | First byte address |
| len_m1 | input | CNT_W | Number of bytes to read minus one |
| mode_bits | input | 8 | Mode byte sent after the address |
| busy | output | 1 | Transaction in progress, including the chip-select gap |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-clock strobe for `rd_data` |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| io_o | output | 2 | Values driven onto data lines 1 and 0 |
| io_oe | output | 2 | Output enables for data lines 1 and 0 |
| io_i | input | 2 | Values sampled from data lines 1 and 0 |

## Verification
The first transaction runs with continuous mode clear. It shows that the command goes out on line 0 alone and that address and mode pairs are interleaved correctly.

A chain of mode bytes follows: `A5`, then `20`, then `FF`, then `10`. This separates the continuous-mode key 2'b10 from other values on bits [5:4] that share some of the same bits. A wrong flag would then show up as a missing or extra command phase.

Other stimulus covers the remaining behaviour:
- Byte counts from 1 to 16 and a start address near the top of the array check byte order and the end-of-transfer timing.
- A start pulse issued mid-transfer shows that requests are ignored while busy.
- A reset during a continuous-mode read shows that reset brings back the command phase.

// File: rtl/dio_pkg.sv
package dio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_MODE,
        ST_DATA,
        ST_GAP
    } dio_state_e;

    localparam logic [7:0] DIO_READ_CMD  = 8'hBB;
    localparam logic [1:0] DIO_CONT_KEY  = 2'b10;
    localparam int         DIO_CMD_CLKS  = 8;
    localparam int         DIO_ADDR_CLKS = 12;
    localparam int         DIO_MODE_CLKS = 4;

endpackage

// File: rtl/dio_sck_gen.sv
module dio_sck_gen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || cnt == CW'(HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF - 1));

endmodule

// File: rtl/dio_rx_pack.sv
module dio_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       sample,
    input  logic [1:0] din,
    output logic [7:0] byte_q,
    output logic       byte_vld
);
    logic [5:0] part;
    logic [1:0] pair_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part     <= '0;
            pair_cnt <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (clear) begin
                pair_cnt <= '0;
            end else if (sample) begin
                part     <= {part[3:0], din};
                pair_cnt <= pair_cnt + 1'b1;
                if (pair_cnt == 2'd3) begin
                    byte_q   <= {part, din};
                    byte_vld <= 1'b1;
                end
            end
        end
    end

    // R5
    pack_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(sample));

endmodule

// File: rtl/dio_read_seq.sv
module dio_read_seq
    import dio_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int CNT_W   = 8,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [23:0]      start_addr,
    input  logic [CNT_W-1:0] len_m1,
    input  logic [7:0]       mode_bits,
    output logic             busy,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             cs_n,
    output logic             sck,
    output logic [1:0]       io_o,
    output logic [1:0]       io_oe,
    input  logic [1:0]       io_i
);
    localparam int BW = CNT_W + 3;
    localparam int GW = $clog2(GAP_CYC + 1);

    dio_state_e       state, nxt;
    logic             tick, run, rise, fall, phase_end, accept;
    logic             sck_q, cs_q, cont_q;
    logic [7:0]       op_sr, mode_q;
    logic [31:0]      tx_sr;
    logic [BW-1:0]    bit_cnt, phase_len, data_clks;
    logic [CNT_W-1:0] len_q;
    logic [GW-1:0]    gap_cnt;

    assign run       = (state == ST_OPC) || (state == ST_ADDR) ||
                       (state == ST_MODE) || (state == ST_DATA);
    assign rise      = tick && !sck_q;
    assign fall      = tick && sck_q;
    assign accept    = (state == ST_IDLE) && start;
    assign data_clks = ({3'b000, len_q} + BW'(1)) << 2;
    assign phase_end = fall && (bit_cnt == phase_len);

    dio_sck_gen #(.CLK_DIV(CLK_DIV)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    dio_rx_pack u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .sample   (rise && (state == ST_DATA)),
        .din      (io_i),
        .byte_q   (rd_data),
        .byte_vld (rd_valid)
    );

    always_comb begin
        phase_len = '0;
        nxt       = state;
        unique case (state)
            ST_IDLE: if (start) nxt = cont_q ? ST_ADDR : ST_OPC;
            ST_OPC: begin
                phase_len = BW'(DIO_CMD_CLKS);
                if (phase_end) nxt = ST_ADDR;
            end
            ST_ADDR: begin
                phase_len = BW'(DIO_ADDR_CLKS);
                if (phase_end) nxt = ST_MODE;
            end
            ST_MODE: begin
                phase_len = BW'(DIO_MODE_CLKS);
                if (phase_end) nxt = ST_DATA;
            end
            ST_DATA: begin
                phase_len = data_clks;
                if (phase_end) nxt = ST_GAP;
            end
            ST_GAP: if (gap_cnt == GW'(GAP_CYC - 1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            cont_q  <= 1'b0;
            op_sr   <= '0;
            tx_sr   <= '0;
            mode_q  <= '0;
            len_q   <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                cs_q    <= 1'b0;
                op_sr   <= DIO_READ_CMD;
                tx_sr   <= {start_addr, mode_bits};
                mode_q  <= mode_bits;
                len_q   <= len_m1;
                bit_cnt <= '0;
            end
            if (rise) begin
                sck_q   <= 1'b1;
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall) begin
                sck_q <= 1'b0;
                if (phase_end) bit_cnt <= '0;
                if (state == ST_OPC) op_sr <= op_sr << 1;
                if ((state == ST_ADDR) || (state == ST_MODE && !phase_end))
                    tx_sr <= tx_sr << 2;
                if (state == ST_MODE && phase_end)
                    cont_q <= (mode_q[5:4] == DIO_CONT_KEY);
                if (state == ST_DATA && phase_end)
                    cs_q <= 1'b1;
            end
            gap_cnt <= (state == ST_GAP) ? gap_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        busy  = (state != ST_IDLE);
        sck   = sck_q;
        cs_n  = cs_q;
        io_o  = 2'b00;
        io_oe = 2'b00;
        unique case (state)
            ST_OPC: begin
                io_oe = 2'b01;
                io_o  = {1'b0, op_sr[7]};
            end
            ST_ADDR, ST_MODE: begin
                io_oe = 2'b11;
                io_o  = tx_sr[31:30];
            end
            default: ;
        endcase
    end

    // R7
    cs_idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R7
    io_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> ($stable(io_o) && $stable(io_oe)));

    // R6
    data_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (io_oe == 2'b00));

    // R10
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n ##1 cs_n);

    // R11
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(len_q));

endmodule

// File: tb/tb_dio_read_seq.sv
`timescale 1ns/1ps
module tb_dio_read_seq;
    localparam int CLK_DIV = 4;
    localparam int CNT_W   = 4;
    localparam int GAP_CYC = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic [23:0]      start_addr;
    logic [CNT_W-1:0] len_m1;
    logic [7:0]       mode_bits;
    logic             busy, rd_valid, cs_n, sck;
    logic [7:0]       rd_data;
    logic [1:0]       io_o, io_oe, io_i;

    dio_read_seq #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .len_m1(len_m1), .mode_bits(mode_bits), .busy(busy), .rd_data(rd_data),
        .rd_valid(rd_valid), .cs_n(cs_n), .sck(sck), .io_o(io_o), .io_oe(io_oe),
        .io_i(io_i)
    );

    always #2.5 clk = ~clk;

    int vec_n = 0, bad_n = 0, cyc = 0;
    bit done_f = 0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    endtask

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
    endfunction

    // reference flash responder and per-clock model
    logic [23:0] q_addr[$];
    logic [7:0]  q_mode[$];
    int          q_len[$];
    logic [23:0] c_addr;
    logic [7:0]  c_mode;
    logic [31:0] hv;
    logic [7:0]  cmd = 8'hBB;
    logic [7:0]  b;
    logic [1:0]  prev_o, prev_oe;
    bit          in_txn = 0, cont_ref = 0, prev_sck = 0, prev_cs = 1, in_gap = 0, exp_v;
    int          c_len, n_rise, hdr, opc_len, since_rise, rx_cnt, gap_n, p, idx, k;
    int          txn_seen = 0, txn_sent = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            in_txn = 0; cont_ref = 0; prev_sck = 0; prev_cs = 1; in_gap = 0;
            io_i = 2'b11;
        end else begin
            if (cs_n) check(sck == 1'b0, "R7 sck idle", 32'(sck), 0);
            if (!cs_n) check(busy == 1'b1, "R10 busy while selected", 32'(busy), 1);
            if (sck && prev_sck)
                check(io_o == prev_o && io_oe == prev_oe, "R7 hold while high",
                      {io_oe, io_o}, {prev_oe, prev_o});
            if (!cs_n && prev_cs) begin
                txn_seen++;
                if (q_addr.size() == 0) begin
                    check(0, "R11 unrequested transaction", txn_seen, txn_sent);
                    c_addr = '0; c_mode = '0; c_len = 0;
                end else begin
                    c_addr = q_addr.pop_front();
                    c_mode = q_mode.pop_front();
                    c_len  = q_len.pop_front();
                end
                in_txn = 1; n_rise = 0; since_rise = 0; rx_cnt = 0; in_gap = 0;
                opc_len = cont_ref ? 0 : 8;
                hdr = opc_len + 16;
                hv = {c_addr, c_mode};
            end
            if (in_txn && !cs_n) begin
                since_rise++;
                if (sck && !prev_sck) begin
                    n_rise++;
                    if (n_rise > 1) check(since_rise == CLK_DIV, "R8 sck period", since_rise, CLK_DIV);
                    if (n_rise == 1)
                        check(io_oe == (opc_len != 0 ? 2'b01 : 2'b11), "R9 first phase",
                              io_oe, (opc_len != 0 ? 2'b01 : 2'b11));
                    since_rise = 0;
                end
                p = n_rise - hdr - 1;
                exp_v = sck && !prev_sck && p >= 0 && (p % 4) == 3;
                check(rd_valid == exp_v, "R5 valid timing", 32'(rd_valid), 32'(exp_v));
                if (exp_v) begin
                    b = flash_byte(c_addr + 24'(p / 4));
                    check(rd_data == b, "R5 byte value", rd_data, b);
                    rx_cnt++;
                end
                idx = sck ? n_rise : n_rise + 1;
                if (idx <= opc_len) begin
                    check(io_oe == 2'b01 && io_o[0] == cmd[8 - idx], "R2 command bit",
                          {io_oe, io_o}, {2'b01, 1'b0, cmd[8 - idx]});
                end else if (idx <= hdr) begin
                    k = idx - opc_len;
                    check(io_oe == 2'b11 && io_o == hv[33 - 2 * k -: 2],
                          (k <= 12) ? "R3 address pair" : "R4 mode pair",
                          {io_oe, io_o}, {2'b11, hv[33 - 2 * k -: 2]});
                end else begin
                    check(io_oe == 2'b00, "R6 lines released", io_oe, 0);
                end
                if (!sck && prev_sck) begin
                    k = n_rise - hdr;
                    if (k >= 0) begin
                        b = flash_byte(c_addr + 24'(k / 4));
                        io_i = b[7 - 2 * (k % 4) -: 2];
                    end else begin
                        io_i = 2'b11;
                    end
                end
            end else begin
                check(rd_valid == 1'b0, "R5 no strobe when deselected", 32'(rd_valid), 0);
            end
            if (cs_n && !prev_cs && in_txn) begin
                check(n_rise == hdr + 4 * c_len, "R10 end after last byte", n_rise, hdr + 4 * c_len);
                check(rx_cnt == c_len, "R5 byte count", rx_cnt, c_len);
                cont_ref = (c_mode[5:4] == 2'b10);
                in_txn = 0; in_gap = 1; gap_n = 0;
            end
            if (in_gap) begin
                check(cs_n == 1'b1, "R10 select high in gap", 32'(cs_n), 1);
                if (busy) gap_n++;
                else begin
                    check(gap_n == GAP_CYC, "R10 gap length", gap_n, GAP_CYC);
                    in_gap = 0;
                end
            end
            prev_sck = sck; prev_cs = cs_n; prev_o = io_o; prev_oe = io_oe;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_f) begin
            bad_n++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
            $finish;
        end
    end

    task automatic launch(input logic [23:0] a, input int nbytes, input logic [7:0] m);
        @(negedge clk);
        while (busy) @(negedge clk);
        q_addr.push_back(a); q_mode.push_back(m); q_len.push_back(nbytes);
        txn_sent++;
        start_addr = a; len_m1 = CNT_W'(nbytes - 1); mode_bits = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", 32'(busy), 1);
    endtask

    task automatic finish_txn();
        while (busy) @(negedge clk);
    endtask

    task automatic run_txn(input logic [23:0] a, input int nbytes, input logic [7:0] m);
        launch(a, nbytes, m);
        finish_txn();
    endtask

    task automatic check_reset_state();
        check(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        check(sck == 1'b0, "R1 sck", 32'(sck), 0);
        check(busy == 1'b0, "R1 busy", 32'(busy), 0);
        check(io_oe == 2'b00, "R1 io_oe", io_oe, 0);
        check(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; start_addr = '0; len_m1 = '0; mode_bits = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        run_txn(24'h123456, 4, 8'h00);   // R2 command, R3 R4 header
        run_txn(24'hABCDEF, 1, 8'hA5);   // sets continuous
        run_txn(24'h00F0F0, 3, 8'h20);   // R9 no command, keeps continuous
        run_txn(24'hFFFFFE, 5, 8'hFF);   // R9 no command, clears; wrap
        run_txn(24'h5A5A5A, 2, 8'h10);   // R9 command again
        run_txn(24'h000000, 16, 8'h5F);  // 5F bits[5:4] = 01, command next

        // R11 start while busy
        launch(24'h0F0F0F, 2, 8'h00);
        repeat (30) @(negedge clk);
        start_addr = 24'h777777; len_m1 = '1; mode_bits = 8'h20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_txn();
        repeat (20) @(negedge clk);
        check(txn_seen == txn_sent, "R11 transaction count", txn_seen, txn_sent);

        // R9 reset clears continuous mode
        run_txn(24'h246802, 1, 8'h20);
        launch(24'h135791, 4, 8'h00);
        repeat (25) @(negedge clk);
        rst_n = 1'b0;
        q_addr.delete(); q_mode.delete(); q_len.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        run_txn(24'h0ABCDE, 2, 8'h00);
        repeat (10) @(negedge clk);

        done_f = 1;
        report();
        $finish;
    end
endmodule